// File: doc/BRIEF.md
# Double-Buffered Pulse-Width Modulator Timer

This block is a 32-bit timer behind a 32-bit prescaler with seven compare values. In PWM mode, compare 0 sets the period length. When the counter reaches it, the counter returns to zero and all six outputs go high. Each of the other six compares sets the falling edge of one output. Software writes new compare values into holding registers. A holding value moves into the active compare only when two conditions are met: software has released it through its own release bit, and the counter is wrapping to zero. Because of this, an output never shows a cut-short or doubled pulse while values change.

With PWM mode off, the same counter serves as a general match timer. Each compare can raise a sticky interrupt flag, send the counter back to zero, or halt it. In this mode a compare write takes effect at once. Software accesses the block through a write-only register port, with addresses decoded on `wr_addr`.

Top module: `pwm_latched_timer`

## Requirements
- R1: After reset the counter reads 0, all outputs are low, all flags are clear, and the control word is zero.
- R2: The prescale register at address 1 holds a limit P. While the counter runs, it advances by one every P+1 clocks.
- R3: The control word is at address 0: bit 0 run, bit 1 hold-at-zero, bit 2 PWM mode. In PWM mode the counter steps through 0..M0 and then wraps to 0, so one period lasts (M0+1)(P+1) clocks.
- R4: In PWM mode, output k (bit k-1 of `pwm_o`, k = 1..6) is set high at each wrap and cleared after the counter has held compare k. It is high while the count is at or below Mk. A value of Mk at or above M0 keeps it high all period. Mk = 0 keeps it high only while the count is 0.
- R5: In PWM mode, a write to compare n (address 8+n) changes only the holding value. The active value stays unchanged until a wrap occurs with release bit n set.
- R6: The release register at address 3 sets release bit n for each 1 written in bit n; 0 bits leave the other release bits unchanged. Every release bit clears at a wrap. A holding value written after that wrap is unused until it is released again.
- R7: With PWM mode off, a compare write loads the active value at once, all outputs stay low, and compare 0 does not restart the counter unless its own reset action is set.
- R8: The action register is at address 2. It holds, for compare i, bit 3i interrupt, bit 3i+1 reset, and bit 3i+2 stop. When the count equals a compare that has its reset action set, the counter goes to 0 on the next step.
- R9: When the count equals a compare that has its stop action set, the run bit clears and the counter keeps its value.
- R10: Flag i sets when the count equals compare i and its interrupt action is set. Flags stay set until a 1 is written to bit i of address 4. `irq_o` is the OR of all flags.
- R11: While hold-at-zero is set, the counter and prescaler stay at 0. In PWM mode the outputs are also held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| count_o | output | 32 | Current counter value |
| pwm_o | output | 6 | PWM outputs 1..6 |
| match_flags_o | output | 7 | Sticky match flags |
| irq_o | output | 1 | OR of all match flags |

## Verification
A register write lands on the clock edge after the bench drives it, and its effect shows at the following falling-edge sample. The counter and the outputs are registered on the same edge, so each falling-edge sample of `count_o` and `pwm_o` belongs to one count value. The scoreboard therefore tallies high samples per output between two observed wraps and compares the tally with the length predicted from (Mk+1)(P+1). Released values are pushed as expectations for the period after the wrap that loads them. Flags and the reset or stop action are read one sample after the count shows the matching value, because they act on the step that leaves it.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [3:0] {
        A_CTRL   = 4'd0,
        A_PRESC  = 4'd1,
        A_ACTION = 4'd2,
        A_LATCH  = 4'd3,
        A_FCLR   = 4'd4,
        A_MATCH0 = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic pwm_mode;
        logic cnt_rst;
        logic cnt_en;
    } ctrl_t;

    typedef struct packed {
        logic stop_on;
        logic rst_on;
        logic int_en;
    } mact_t;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clear,
    input  logic [TW-1:0] limit,
    output logic          tick
);
    logic [TW-1:0] pc_q;

    assign tick = run && (pc_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || clear)
            pc_q <= '0;
        else if (run)
            pc_q <= tick ? '0 : pc_q + 1'b1;
    end
endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
    parameter int TW = 32,
    parameter int NM = 7,
    parameter int IW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             direct,
    input  logic             wr_match,
    input  logic [IW-1:0]    wr_idx,
    input  logic [TW-1:0]    wr_data,
    input  logic             le_set_en,
    input  logic [NM-1:0]    le_set,
    input  logic             wrap,
    output logic [NM*TW-1:0] act_flat,
    output logic [NM-1:0]    le_o
);
    logic [NM-1:0] le_q;

    always_ff @(posedge clk) begin
        if (rst)
            le_q <= '0;
        else
            le_q <= (wrap ? '0 : le_q) | (le_set_en ? le_set : '0);
    end
    assign le_o = le_q;

    for (genvar i = 0; i < NM; i++) begin : g_slot
        logic [TW-1:0] shadow_q;
        logic [TW-1:0] act_q;
        logic          sel;
        assign sel = wr_match && (wr_idx == IW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q <= '0;
                act_q    <= '0;
            end else begin
                if (sel)
                    shadow_q <= wr_data;
                if (sel && direct)
                    act_q <= wr_data;
                else if (wrap && le_q[i])
                    act_q <= shadow_q;
            end
        end
        assign act_flat[i*TW +: TW] = act_q;
    end
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
    parameter int NO = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          hold,
    input  logic          wrap,
    input  logic [NO-1:0] fall,
    output logic [NO-1:0] pwm_o
);
    for (genvar k = 0; k < NO; k++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst || !enable)
                pwm_o[k] <= 1'b0;
            else if (hold || wrap)
                pwm_o[k] <= 1'b1;
            else if (fall[k])
                pwm_o[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_latched_timer.sv
module pwm_latched_timer
    import pwm_pkg::*;
#(
    parameter int TW        = 32,
    parameter int NUM_MATCH = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [3:0]           wr_addr,
    input  logic [TW-1:0]        wr_data,
    output logic [TW-1:0]        count_o,
    output logic [NUM_MATCH-2:0] pwm_o,
    output logic [NUM_MATCH-1:0] match_flags_o,
    output logic                 irq_o
);
    localparam int NO = NUM_MATCH - 1;
    localparam int IW = $clog2(NUM_MATCH);
    localparam int AB = 3 * NUM_MATCH;

    ctrl_t                        ctrl_q;
    logic  [TW-1:0]               presc_q;
    logic  [TW-1:0]               count_q;
    mact_t [NUM_MATCH-1:0]        mact_q;
    logic  [NUM_MATCH-1:0]        flags_q;
    logic  [NUM_MATCH*TW-1:0]     act_flat;
    logic  [NUM_MATCH-1:0]        le_q;
    logic  [NUM_MATCH-1:0]        hit, rst_mask, stop_mask, int_mask;
    logic                         tick, wrap, stop_hit;
    logic                         wr_ctrl, wr_presc, wr_act, wr_latch, wr_fclr, wr_match;
    logic  [IW-1:0]               midx;
    logic                         pwm_mode_w, cnt_en_w, cnt_rst_w;

    assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
    assign wr_presc = wr_en && (wr_addr == A_PRESC);
    assign wr_act   = wr_en && (wr_addr == A_ACTION);
    assign wr_latch = wr_en && (wr_addr == A_LATCH);
    assign wr_fclr  = wr_en && (wr_addr == A_FCLR);
    assign midx     = wr_addr[IW-1:0];
    assign wr_match = wr_en && wr_addr[3] && (int'(midx) < NUM_MATCH);

    assign pwm_mode_w = ctrl_q.pwm_mode;
    assign cnt_en_w   = ctrl_q.cnt_en;
    assign cnt_rst_w  = ctrl_q.cnt_rst;

    pwm_prescaler #(.TW(TW)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl_q.cnt_en && !ctrl_q.cnt_rst),
        .clear (ctrl_q.cnt_rst),
        .limit (presc_q),
        .tick  (tick)
    );

    pwm_match_bank #(.TW(TW), .NM(NUM_MATCH), .IW(IW)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .direct    (!ctrl_q.pwm_mode),
        .wr_match  (wr_match),
        .wr_idx    (midx),
        .wr_data   (wr_data),
        .le_set_en (wr_latch),
        .le_set    (wr_data[NUM_MATCH-1:0]),
        .wrap      (wrap),
        .act_flat  (act_flat),
        .le_o      (le_q)
    );

    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_cmp
        assign hit[i]       = tick && (count_q == act_flat[i*TW +: TW]);
        assign rst_mask[i]  = mact_q[i].rst_on;
        assign stop_mask[i] = mact_q[i].stop_on;
        assign int_mask[i]  = mact_q[i].int_en;
    end

    assign wrap     = (ctrl_q.pwm_mode && hit[0]) || (|(hit & rst_mask));
    assign stop_hit = |(hit & stop_mask);

    pwm_edge_gen #(.NO(NO)) u_edges (
        .clk    (clk),
        .rst    (rst),
        .enable (ctrl_q.pwm_mode),
        .hold   (ctrl_q.cnt_rst),
        .wrap   (wrap),
        .fall   (hit[NUM_MATCH-1:1]),
        .pwm_o  (pwm_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            presc_q <= '0;
            mact_q  <= '0;
            flags_q <= '0;
            count_q <= '0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(wr_data[2:0]);
            else if (stop_hit)
                ctrl_q.cnt_en <= 1'b0;
            if (wr_presc)
                presc_q <= wr_data;
            if (wr_act)
                mact_q <= wr_data[AB-1:0];
            flags_q <= (flags_q & ~(wr_fclr ? wr_data[NUM_MATCH-1:0] : '0))
                     | (hit & int_mask);
            if (ctrl_q.cnt_rst)
                count_q <= '0;
            else if (tick) begin
                if (wrap)
                    count_q <= '0;
                else if (!stop_hit)
                    count_q <= count_q + 1'b1;
            end
        end
    end

    assign count_o       = count_q;
    assign match_flags_o = flags_q;
    assign irq_o         = |flags_q;
endmodule

// File: rtl/pwm_latched_timer_chk.sv
module pwm_latched_timer_chk #(
    parameter int TW = 32,
    parameter int NM = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [3:0]       wr_addr,
    input logic             cnt_en,
    input logic             cnt_rst,
    input logic             pwm_mode,
    input logic             tick,
    input logic             wrap,
    input logic             stop_hit,
    input logic [TW-1:0]    count,
    input logic [NM*TW-1:0] act_flat,
    input logic [NM-1:0]    le,
    input logic [NM-2:0]    pwm,
    input logic [NM-1:0]    flags
);
    AST_COUNT_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_rst) |=> $stable(count)); // R2
    AST_RISE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (|(pwm & ~$past(pwm))) |-> $past(wrap || cnt_rst)); // R4
    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (rst)
        (pwm_mode && !wrap) |=> $stable(act_flat)); // R5
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wrap && !(wr_en && wr_addr == 4'd3)) |=> (le == '0)); // R6
    AST_TIMER_OUT_LOW: assert property (@(posedge clk) disable iff (rst)
        !pwm_mode |=> (pwm == '0)); // R7
    AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
        (stop_hit && !(wr_en && wr_addr == 4'd0)) |=> !cnt_en); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|(~flags & $past(flags))) |-> $past(wr_en && wr_addr == 4'd4)); // R10
    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
        cnt_rst |=> (count == '0)); // R11
endmodule

bind pwm_latched_timer pwm_latched_timer_chk #(.TW(TW), .NM(NUM_MATCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .cnt_en   (cnt_en_w),
    .cnt_rst  (cnt_rst_w),
    .pwm_mode (pwm_mode_w),
    .tick     (tick),
    .wrap     (wrap),
    .stop_hit (stop_hit),
    .count    (count_q),
    .act_flat (act_flat),
    .le       (le_q),
    .pwm      (pwm_o),
    .flags    (flags_q)
);

// File: tb/tb_pwm_latched_timer.sv
module tb_pwm_latched_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] count;
    logic [5:0]  pwm;
    logic [6:0]  flags;
    logic        irq;

    int checks = 0;
    int errors = 0;

    typedef struct { int len; int hi[6]; } exp_t;
    exp_t  sb[$];
    string sb_tag = "";
    bit    mon_en = 1'b0;
    int    idx = 0;

    always #10 clk = ~clk;

    pwm_latched_timer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count_o(count), .pwm_o(pwm), .match_flags_o(flags), .irq_o(irq)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push(input int len, input int h1, input int h2, input int h3,
                        input int h4, input int h5, input int h6);
        exp_t e;
        e.len = len;
        e.hi[0] = h1; e.hi[1] = h2; e.hi[2] = h3;
        e.hi[3] = h4; e.hi[4] = h5; e.hi[5] = h6;
        sb.push_back(e);
    endtask

    // Monitor: tallies each period between observed wraps and pops the scoreboard
    initial begin
        int          cyc;
        int          hi[6];
        bit          armed;
        logic [31:0] prev;
        exp_t        e;
        armed = 0; prev = '0; cyc = 0;
        foreach (hi[k]) hi[k] = 0;
        forever begin
            @(negedge clk);
            if (!mon_en) begin
                armed = 0; idx = 0; prev = count;
            end else begin
                if (prev != 0 && count == 0) begin
                    if (armed) begin
                        if (sb.size() == 0) begin
                            check({sb_tag, " unexpected period"}, cyc, -1);
                        end else begin
                            e = sb.pop_front();
                            check({sb_tag, " period length"}, cyc, e.len);
                            for (int k = 0; k < 6; k++)
                                check($sformatf("%s out%0d high clocks", sb_tag, k + 1), hi[k], e.hi[k]);
                        end
                    end
                    armed = 1; cyc = 0;
                    foreach (hi[k]) hi[k] = 0;
                    idx++;
                end
                if (armed) begin
                    cyc++;
                    for (int k = 0; k < 6; k++) hi[k] += int'(pwm[k]);
                end
                prev = count;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 count after reset", count, 0);
        check("R1 outputs after reset", pwm, 0);
        check("R1 flags after reset", flags, 0);

        // Scenario A: PWM, prescale 0, values loaded directly in timer mode under hold
        wr(4'd0, 32'h2);
        wr(4'd1, 0);
        wr(4'd8, 9);  wr(4'd9, 3);  wr(4'd10, 0); wr(4'd11, 9);
        wr(4'd12, 15); wr(4'd13, 5); wr(4'd14, 7);
        wr(4'd0, 32'h6);
        @(negedge clk);
        check("R11 hold drives outputs high", pwm, 6'h3f);
        check("R11 hold keeps count zero", count, 0);
        sb_tag = "R3 R4 R5 R6";
        push(10, 4, 1, 10, 10, 6, 8);
        push(10, 4, 1, 10, 10, 2, 8);
        push(5, 5, 1, 5, 5, 2, 5);
        push(5, 5, 1, 5, 5, 2, 5);
        wr(4'd0, 32'h5);
        mon_en = 1'b1;
        wait (idx == 1);
        wr(4'd9, 6);
        wr(4'd13, 1);
        wr(4'd3, 32'h20);
        wait (idx == 2);
        wr(4'd9, 7);
        wr(4'd8, 4);
        wr(4'd3, 32'h3);
        wait (idx == 3);
        wr(4'd10, 2);
        wait (idx == 5);
        mon_en = 1'b0;
        check("R5 R6 scoreboard drained", sb.size(), 0);

        // Scenario B: prescale 2
        wr(4'd0, 32'h2);
        wr(4'd1, 2);
        wr(4'd8, 3);
        wr(4'd9, 1);
        wr(4'd0, 32'h6);
        sb_tag = "R2 R3 R4";
        push(12, 6, 3, 12, 12, 6, 12);
        push(12, 6, 3, 12, 12, 6, 12);
        wr(4'd0, 32'h5);
        mon_en = 1'b1;
        wait (idx == 3);
        mon_en = 1'b0;
        check("R2 scoreboard drained", sb.size(), 0);

        // Scenario C: plain timer mode
        wr(4'd0, 32'h2);
        wr(4'd1, 0);
        wr(4'd8, 3);
        wr(4'd9, 4);
        wr(4'd2, 32'h18);
        wr(4'd0, 32'h1);
        for (int n = 0; n < 20 && count != 4; n++) @(negedge clk);
        check("R7 count passes compare 0 in timer mode", count, 4);
        check("R7 outputs low in timer mode", pwm, 0);
        @(negedge clk);
        check("R8 reset action returns count to zero", count, 0);
        check("R10 flag 1 set", flags[1], 1);
        check("R10 irq raised", irq, 1);
        check("R10 flag 0 not enabled", flags[0], 0);
        wr(4'd4, 32'h2);
        check("R10 flag 1 cleared", flags[1], 0);
        check("R10 irq dropped", irq, 0);
        wr(4'd10, 2);
        wr(4'd2, 32'h158);
        repeat (20) @(negedge clk);
        check("R9 counter halted at compare 2", count, 2);
        check("R10 flag 2 set by stop compare", flags[2], 1);
        repeat (5) @(negedge clk);
        check("R9 counter still halted", count, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule